// File: doc/BRIEF.md
# SPI Command Frame Encoder

This block sits on the host side of a byte-oriented SPI link to a peripheral. It takes one command (an opcode, a 24-bit address, a 24-bit transfer size, a 32-bit data word, a clockless flag and a CRC-enable flag) and turns it into the byte sequence that goes out on the wire. The opcode decides which argument fields follow it. An optional CRC7 trailer closes the command bytes. A run of zero bytes then follows, and its length also depends on the opcode. During that run the peripheral answers.

Bytes are handed one at a time to a downstream SPI shifter over a valid/ready stream. The shifter sends each byte most significant bit first. The chip-select output is held low for exactly the duration of one frame. A new command is taken only while the block is idle. An opcode outside the supported set produces a one-cycle error pulse and no frame. The CRC is accumulated serially, one byte per accepted handshake, so no lookup table is needed.

Top module: `spi_cmd_framer`

## Requirements
- R1: After reset, cs_n is 1, tx_valid is 0, err_pulse is 0 and cmd_ready is 1.
- R2: A command whose opcode is not one of 0xC1–0xC8, 0xC9, 0xCA or 0xCF is consumed, raises err_pulse for exactly one cycle after acceptance, and produces no frame: cs_n stays 1 and tx_valid stays 0.
- R3: Address-based opcodes send the opcode, then address bits 23:16, 15:8, 7:0. After that, single write (0xC9) adds the data word MSB first; DMA write/read (0xC1/0xC2) add size bits 15:8 and 7:0; extended DMA write/read (0xC7/0xC8) add size bits 23:16, 15:8 and 7:0; single read (0xCA) adds nothing.
- R4: Internal write (0xC3) and internal read (0xC4) send the opcode, then address bits 15:8 with bit 7 forced to 1 when cmd_clockless is 1, then address bits 7:0. Internal write follows with the data word MSB first, and internal read follows with one 0x00 byte.
- R5: Terminate (0xC5) and repeat (0xC6) send three 0x00 argument bytes after the opcode, and reset (0xCF) sends three 0xFF bytes.
- R6: With cmd_crc_en = 1, the byte after the command bytes is {crc, 0}. Here crc is the CRC7 with polynomial x^7+x^3+1, initial value 0x7F, taken over every preceding byte of the frame, each byte MSB first.
- R7: With cmd_crc_en = 0, no CRC byte is sent and the padding follows the command bytes directly.
- R8: The frame ends with zero bytes: 6 for 0xC5, 0xC6 and 0xCF; 10 (CRC on) or 8 (CRC off) for 0xC4 and 0xCA; 5 for every other supported opcode.
- R9: cs_n is 0 from the cycle after a valid command is accepted until the handshake of the last frame byte, then returns to 1. cmd_ready is 0 during that time, and a cmd_valid presented then is ignored.
- R10: While tx_valid is 1 and tx_ready is 0, tx_valid and tx_byte hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command taken when valid |
| cmd_op | input | 8 | Opcode |
| cmd_addr | input | 24 | Target address |
| cmd_size | input | 24 | Transfer size for DMA opcodes |
| cmd_data | input | 32 | Data word for write opcodes |
| cmd_clockless | input | 1 | Set bit 7 of the high internal address byte |
| cmd_crc_en | input | 1 | Append CRC7 trailer and use CRC-on padding |
| err_pulse | output | 1 | One-cycle flag for a rejected opcode |
| cs_n | output | 1 | Active-low chip select for the frame |
| tx_valid | output | 1 | Frame byte available |
| tx_ready | input | 1 | Shifter takes the byte |
| tx_byte | output | 8 | Frame byte, shifted out MSB first |

## Verification
The block has no tunable parameters, so the bench uses the fixed byte layout and exercises all eleven opcodes. It reaches the longest frame (single read with CRC, 15 bytes) and the shortest (control opcodes without CRC, 10 bytes). It also sets the clockless bit both on an address whose bit 15 is clear and on one whose bit 15 is already set. Three ready patterns (always ready, every other cycle, one cycle in four) bring the stall-hold rule and the CRC accumulation under back-pressure within reach. A command presented in the middle of a frame covers the idle-only acceptance rule.

// File: rtl/spi_cmd_framer.sv
module spi_cmd_framer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [7:0]  cmd_op,
  input  logic [23:0] cmd_addr,
  input  logic [23:0] cmd_size,
  input  logic [31:0] cmd_data,
  input  logic        cmd_clockless,
  input  logic        cmd_crc_en,
  output logic        err_pulse,
  output logic        cs_n,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_byte
);

  localparam logic [6:0] CRC_SEED = 7'h7F;

  logic       busy;
  logic [4:0] idx;
  logic [4:0] last_idx;
  logic [3:0] hdr_len;
  logic       crc_on;
  logic [6:0] crc;
  logic       err_q;
  logic [7:0] hdr [16];

  logic [7:0] nb [16];
  logic [3:0] n_hdr;
  logic [3:0] n_pad;
  logic       op_ok;
  logic [7:0] int_hi;

  function automatic logic [6:0] crc_step(input logic [6:0] c, input logic [7:0] d);
    logic [6:0] r;
    logic       fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[6] ^ d[i];
      r  = {r[5:0], 1'b0};
      if (fb) r = r ^ 7'h09;
    end
    return r;
  endfunction

  assign int_hi = {cmd_clockless | cmd_addr[15], cmd_addr[14:8]};

  always_comb begin
    for (int i = 0; i < 16; i++) nb[i] = 8'h00;
    nb[0] = cmd_op;
    n_hdr = 4'd4;
    n_pad = 4'd5;
    op_ok = 1'b1;
    case (cmd_op)
      8'hC1, 8'hC2: begin
        nb[1] = cmd_addr[23:16]; nb[2] = cmd_addr[15:8]; nb[3] = cmd_addr[7:0];
        nb[4] = cmd_size[15:8];  nb[5] = cmd_size[7:0];
        n_hdr = 4'd6;
      end
      8'hC7, 8'hC8: begin
        nb[1] = cmd_addr[23:16]; nb[2] = cmd_addr[15:8]; nb[3] = cmd_addr[7:0];
        nb[4] = cmd_size[23:16]; nb[5] = cmd_size[15:8]; nb[6] = cmd_size[7:0];
        n_hdr = 4'd7;
      end
      8'hC3: begin
        nb[1] = int_hi; nb[2] = cmd_addr[7:0];
        nb[3] = cmd_data[31:24]; nb[4] = cmd_data[23:16];
        nb[5] = cmd_data[15:8];  nb[6] = cmd_data[7:0];
        n_hdr = 4'd7;
      end
      8'hC4: begin
        nb[1] = int_hi; nb[2] = cmd_addr[7:0];
        n_pad = cmd_crc_en ? 4'd10 : 4'd8;
      end
      8'hC5, 8'hC6: n_pad = 4'd6;
      8'hCF: begin
        nb[1] = 8'hFF; nb[2] = 8'hFF; nb[3] = 8'hFF;
        n_pad = 4'd6;
      end
      8'hC9: begin
        nb[1] = cmd_addr[23:16]; nb[2] = cmd_addr[15:8]; nb[3] = cmd_addr[7:0];
        nb[4] = cmd_data[31:24]; nb[5] = cmd_data[23:16];
        nb[6] = cmd_data[15:8];  nb[7] = cmd_data[7:0];
        n_hdr = 4'd8;
      end
      8'hCA: begin
        nb[1] = cmd_addr[23:16]; nb[2] = cmd_addr[15:8]; nb[3] = cmd_addr[7:0];
        n_pad = cmd_crc_en ? 4'd10 : 4'd8;
      end
      default: op_ok = 1'b0;
    endcase
  end

  assign cmd_ready = ~busy;
  assign cs_n      = ~busy;
  assign tx_valid  = busy;
  assign err_pulse = err_q;

  assign tx_byte = (idx < {1'b0, hdr_len}) ? hdr[idx[3:0]] :
                   (crc_on && idx == {1'b0, hdr_len}) ? {crc, 1'b0} : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      idx      <= '0;
      last_idx <= '0;
      hdr_len  <= '0;
      crc_on   <= 1'b0;
      crc      <= CRC_SEED;
      err_q    <= 1'b0;
      for (int i = 0; i < 16; i++) hdr[i] <= 8'h00;
    end else begin
      err_q <= cmd_valid && !busy && !op_ok;
      if (!busy) begin
        if (cmd_valid && op_ok) begin
          busy     <= 1'b1;
          idx      <= '0;
          crc      <= CRC_SEED;
          hdr_len  <= n_hdr;
          crc_on   <= cmd_crc_en;
          last_idx <= {1'b0, n_hdr} + {4'd0, cmd_crc_en} + {1'b0, n_pad} - 5'd1;
          for (int i = 0; i < 16; i++) hdr[i] <= nb[i];
        end
      end else if (tx_ready) begin
        if (idx < {1'b0, hdr_len}) crc <= crc_step(crc, tx_byte);
        if (idx == last_idx) busy <= 1'b0;
        else                 idx  <= idx + 5'd1;
      end
    end
  end

endmodule

// File: rtl/spi_cmd_framer_chk.sv
module spi_cmd_framer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic       err_pulse,
  input logic       cs_n,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_byte
);

  logic [4:0] nsent;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    nsent <= '0;
    else if (cmd_valid && cmd_ready) nsent <= '0;
    else if (tx_valid && tx_ready) nsent <= nsent + 5'd1;
  end

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));

  // R9
  byte_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (!cs_n && !cmd_ready));

  // R2
  err_no_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (cs_n && !tx_valid));

  // R8
  frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (nsent >= 5'd10 && nsent <= 5'd15));

endmodule

bind spi_cmd_framer spi_cmd_framer_chk u_chk (.*);

// File: tb/test_spi_cmd_framer.sv
module test_spi_cmd_framer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [7:0]  cmd_op = '0;
  logic [23:0] cmd_addr = '0;
  logic [23:0] cmd_size = '0;
  logic [31:0] cmd_data = '0;
  logic        cmd_clockless = 1'b0;
  logic        cmd_crc_en = 1'b0;
  logic        err_pulse;
  logic        cs_n;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [7:0]  tx_byte;

  int checks = 0;
  int fails  = 0;
  logic [7:0] exp_b [32];
  int exp_n;

  always #10 clk = ~clk;

  spi_cmd_framer i_spi_cmd_framer (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [6:0] ref_crc(input logic [6:0] c, input logic [7:0] d);
    logic [6:0] r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[6] ^ d[i]) r = {r[5:0], 1'b0} ^ 7'h09;
      else             r = {r[5:0], 1'b0};
    end
    return r;
  endfunction

  task automatic build_exp(input [7:0] op, input [23:0] a, input [23:0] s,
                           input [31:0] d, input bit ck, input bit crc);
    int n = 1;
    int pad = 5;
    logic [6:0] c = 7'h7F;
    logic [7:0] hi = {ck | a[15], a[14:8]};
    exp_b[0] = op;
    case (op)
      8'hC1, 8'hC2: begin exp_b[1]=a[23:16]; exp_b[2]=a[15:8]; exp_b[3]=a[7:0];
                          exp_b[4]=s[15:8]; exp_b[5]=s[7:0]; n=6; end
      8'hC7, 8'hC8: begin exp_b[1]=a[23:16]; exp_b[2]=a[15:8]; exp_b[3]=a[7:0];
                          exp_b[4]=s[23:16]; exp_b[5]=s[15:8]; exp_b[6]=s[7:0]; n=7; end
      8'hC3: begin exp_b[1]=hi; exp_b[2]=a[7:0]; exp_b[3]=d[31:24]; exp_b[4]=d[23:16];
                   exp_b[5]=d[15:8]; exp_b[6]=d[7:0]; n=7; end
      8'hC4: begin exp_b[1]=hi; exp_b[2]=a[7:0]; exp_b[3]=8'h00; n=4; pad = crc ? 10 : 8; end
      8'hC5, 8'hC6: begin exp_b[1]=0; exp_b[2]=0; exp_b[3]=0; n=4; pad=6; end
      8'hCF: begin exp_b[1]=8'hFF; exp_b[2]=8'hFF; exp_b[3]=8'hFF; n=4; pad=6; end
      8'hC9: begin exp_b[1]=a[23:16]; exp_b[2]=a[15:8]; exp_b[3]=a[7:0]; exp_b[4]=d[31:24];
                   exp_b[5]=d[23:16]; exp_b[6]=d[15:8]; exp_b[7]=d[7:0]; n=8; end
      default: begin exp_b[1]=a[23:16]; exp_b[2]=a[15:8]; exp_b[3]=a[7:0]; n=4; pad = crc ? 10 : 8; end
    endcase
    for (int i = 0; i < n; i++) c = ref_crc(c, exp_b[i]);
    if (crc) begin exp_b[n] = {c, 1'b0}; n++; end
    for (int i = 0; i < pad; i++) exp_b[n+i] = 8'h00;
    exp_n = n + pad;
  endtask

  task automatic run_frame(input string req, input [7:0] op, input [23:0] a, input [23:0] s,
                           input [31:0] d, input bit ck, input bit crc,
                           input int mode, input bit inject);
    logic [7:0] got [32];
    int n = 0;
    bit seen = 0, bad_stall = 0, bad_busy = 0, prev_hold = 0, bytes_ok = 1;
    int bad_i = 0;
    logic [7:0] prev_b = 0;
    build_exp(op, a, s, d, ck, crc);
    @(negedge clk);
    cmd_op = op; cmd_addr = a; cmd_size = s; cmd_data = d;
    cmd_clockless = ck; cmd_crc_en = crc; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = inject;
    if (inject) cmd_op = 8'h00;
    for (int cyc = 0; cyc < 200; cyc++) begin
      tx_ready = (mode == 0) ? 1'b1 : (mode == 1) ? (cyc % 2 == 1) : (cyc % 4 == 3);
      #1;
      if (prev_hold && !(tx_valid && tx_byte == prev_b)) bad_stall = 1;
      if (err_pulse) bad_busy = 1;
      if (!cs_n) begin
        seen = 1;
        if (cmd_ready) bad_busy = 1;
      end else if (seen) break;
      prev_hold = tx_valid && !tx_ready;
      prev_b = tx_byte;
      if (tx_valid && tx_ready) begin
        if (n < 32) got[n] = tx_byte;
        n++;
      end
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    tx_ready = 1'b0;
    check(n == exp_n, req, "frame length", n, exp_n);
    for (int i = 0; i < exp_n && i < n; i++)
      if (bytes_ok && got[i] !== exp_b[i]) begin bytes_ok = 0; bad_i = i; end
    check(bytes_ok, req, $sformatf("byte %0d", bad_i), got[bad_i], exp_b[bad_i]);
    if (mode != 0) check(!bad_stall, "R10", "stall hold", bad_stall, 0);
    if (inject) begin
      check(!bad_busy, "R9", "command taken while busy", bad_busy, 0);
      repeat (3) @(negedge clk);
      #1 check(cs_n && !tx_valid && !err_pulse, "R9", "no second frame", cs_n, 1);
    end
  endtask

  task automatic t_reset;
    #1 check(cs_n === 1'b1 && tx_valid === 1'b0 && err_pulse === 1'b0 && cmd_ready === 1'b1,
             "R1", "reset outputs", {cs_n, tx_valid, err_pulse, cmd_ready}, 4'b1001);
  endtask

  task automatic t_bad_op(input [7:0] op);
    @(negedge clk);
    cmd_op = op; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    #1 check(err_pulse === 1'b1 && cs_n === 1'b1, "R2", "error pulse", err_pulse, 1);
    @(negedge clk);
    #1 check(err_pulse === 1'b0, "R2", "pulse width", err_pulse, 0);
    repeat (3) @(negedge clk);
    #1 check(cs_n === 1'b1 && tx_valid === 1'b0, "R2", "no frame", tx_valid, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R9 watchdog expired: actual running expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #5;
    t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    run_frame("R3 R6", 8'hC9, 24'h123456, 0, 32'hDEADBEEF, 0, 1, 0, 0);
    run_frame("R3 R8", 8'hCA, 24'hA5C30F, 0, 0, 0, 1, 0, 0);
    run_frame("R7 R8", 8'hCA, 24'h00FF10, 0, 0, 0, 0, 0, 0);
    run_frame("R3 R6", 8'hC1, 24'h0B0C0D, 24'h001234, 0, 0, 1, 1, 0);
    run_frame("R3 R6", 8'hC2, 24'h700001, 24'h00FFEE, 0, 0, 1, 0, 0);
    run_frame("R3 R7", 8'hC8, 24'h102030, 24'hABCDEF, 0, 0, 0, 2, 0);
    run_frame("R3 R6", 8'hC7, 24'hFEDCBA, 24'h000105, 0, 0, 1, 0, 0);
    run_frame("R4 R6", 8'hC3, 24'h000024, 0, 32'h01020304, 1, 1, 0, 0);
    run_frame("R4 R8", 8'hC4, 24'h000A10, 0, 0, 0, 1, 1, 0);
    run_frame("R4 R7", 8'hC4, 24'h008A10, 0, 0, 1, 0, 0, 0);
    run_frame("R5 R8", 8'hC5, 0, 0, 0, 0, 1, 0, 0);
    run_frame("R5 R7", 8'hC6, 24'h777777, 0, 0, 0, 0, 0, 0);
    run_frame("R5 R6", 8'hCF, 0, 0, 0, 0, 1, 2, 0);
    run_frame("R9", 8'hC9, 24'h000030, 0, 32'hCAFEF00D, 0, 1, 1, 1);
    t_bad_op(8'h5A);
    t_bad_op(8'hCB);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule